// File: doc/BRIEF.md
# CAN Transmit Bit Stuffing Inserter

This block sits between a CAN frame builder and the transmit bit-timing logic. The upstream logic hands it one unstuffed frame bit per ready/valid handshake. With each bit comes a marker for the start-of-frame bit and a flag that says whether the bit belongs to the stuffed part of the frame. The block forwards every bit in order. Whenever the stuffed part holds five equal bits in a row, it adds one bit of the opposite level. It also keeps an exact count of the stuff bits it added in the current frame.

The stuffed region opens with the start-of-frame bit and runs to the end of the CRC field. The frame builder clears the flag from the CRC delimiter onward. The first bit accepted with the flag low closes the region. That bit leaves the block together with a one-cycle done pulse, and the finished stuff count is shown on its output at that moment. The count cannot come from a formula, because it depends on the actual bit values, so the block scans them one by one.

Top module: `can_stuff_tx`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, frame_done is 0 and stuff_count is 0.
- R2: A bit accepted while no stuff bit is pending (in_valid and in_ready high at a clock edge) appears on out_bit one cycle later, with out_valid 1 and out_stuff 0. Bits leave in the order they were accepted.
- R3: Inside the stuffed region, once five consecutive output bits have the same level, the next output is a stuff bit of the opposite level, marked by out_stuff = 1.
- R4: A stuff bit counts as the first bit of the next run. For example, a stuff bit 1 followed by four data 1s forces another stuff bit 0.
- R5: In the cycle after the fifth equal bit is accepted, in_ready is 0 for exactly one cycle. The stuff bit appears on the output in the following cycle.
- R6: A bit accepted with in_sof = 1 and in_stuff_en = 1 restarts the run from that bit, clears the stuff count and opens the stuffed region. The start-of-frame bit itself belongs to the region.
- R7: Bits accepted with in_stuff_en = 0 are passed through without any stuff bit, however long their runs of equal levels.
- R8: The first bit accepted with in_stuff_en = 0 after the region is output together with a single-cycle frame_done. In that cycle, stuff_count equals the number of stuff bits inserted since the start of frame.
- R9: A run of five that ends on the last bit of the region still gets its stuff bit, which is emitted before the first bit outside the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame bit offered |
| in_ready | output | 1 | Block can take a bit this cycle |
| in_bit | input | 1 | Unstuffed frame bit (0 dominant) |
| in_sof | input | 1 | Offered bit is the start-of-frame bit |
| in_stuff_en | input | 1 | Offered bit lies in the stuffed region |
| out_valid | output | 1 | out_bit carries a bit this cycle |
| out_bit | output | 1 | Stuffed bit stream |
| out_stuff | output | 1 | Current output bit is an inserted stuff bit |
| frame_done | output | 1 | One-cycle pulse when the stuffed region has ended |
| stuff_count | output | CNT_W | Stuff bits inserted in the current frame |

## Verification
Each accepted bit is due at the output exactly one clock later. A stuff bit comes one cycle after the stall cycle in which in_ready is low. The done pulse and the final count arrive in the same cycle as the first bit from outside the region. The bench drives inputs and samples outputs on the falling edge. A reference model builds the expected output queue, and each output cycle pops one entry from it, so any extra, missing or late bit shows up as a mismatch in that cycle. Every bit pattern of a ten-bit region is swept, with and without idle gaps between offered bits.

// File: rtl/cst_pkg.sv
package cst_pkg;
    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_DATA  = 2'd1,
        K_STUFF = 2'd2
    } out_kind_e;
endpackage

// File: rtl/cst_run_eval.sv
module cst_run_eval #(
    parameter int RUN_LIMIT = 5,
    parameter int RUN_W     = 3
) (
    input  logic [RUN_W-1:0] run_i,
    input  logic             last_i,
    input  logic             bit_i,
    output logic [RUN_W-1:0] run_o,
    output logic             hit_o
);
    // a zero run means no history: the bit opens a fresh run
    always_comb begin
        if (run_i != '0 && bit_i == last_i) begin
            run_o = run_i + RUN_W'(1);
        end else begin
            run_o = RUN_W'(1);
        end
        hit_o = (run_o == RUN_W'(RUN_LIMIT));
    end
endmodule

// File: rtl/cst_out_reg.sv
module cst_out_reg
    import cst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_kind_e kind_d,
    input  logic      bit_d,
    input  logic      done_d,
    output logic      out_valid,
    output logic      out_bit,
    output logic      out_stuff,
    output logic      frame_done
);
    typedef struct packed {
        logic vld;
        logic dat;
        logic stf;
        logic dne;
    } o_t;

    o_t o_d, o_q;

    always_comb begin
        o_d.vld = (kind_d != K_NONE);
        o_d.dat = bit_d;
        o_d.stf = (kind_d == K_STUFF);
        o_d.dne = done_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid  = o_q.vld;
    assign out_bit    = o_q.dat;
    assign out_stuff  = o_q.stf;
    assign frame_done = o_q.dne;
endmodule

// File: rtl/can_stuff_tx.sv
module can_stuff_tx
    import cst_pkg::*;
#(
    parameter int RUN_LIMIT = 5,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_bit,
    input  logic             in_sof,
    input  logic             in_stuff_en,
    output logic             out_valid,
    output logic             out_bit,
    output logic             out_stuff,
    output logic             frame_done,
    output logic [CNT_W-1:0] stuff_count
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             last;
        logic             pend;
        logic             region;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d, st_q;
    logic             accept;
    logic             stuffing;
    logic [RUN_W-1:0] ev_run;
    logic             ev_hit;
    out_kind_e        kind_d;
    logic             obit_d;
    logic             done_d;

    assign in_ready = !st_q.pend;
    assign accept   = in_valid && in_ready;
    assign stuffing = in_stuff_en && (in_sof || st_q.region);

    cst_run_eval #(
        .RUN_LIMIT (RUN_LIMIT),
        .RUN_W     (RUN_W)
    ) u_eval (
        .run_i  (in_sof ? '0 : st_q.run),
        .last_i (st_q.last),
        .bit_i  (in_bit),
        .run_o  (ev_run),
        .hit_o  (ev_hit)
    );

    always_comb begin
        st_d   = st_q;
        kind_d = K_NONE;
        obit_d = 1'b0;
        done_d = 1'b0;
        if (st_q.pend) begin
            // emit the opposite level; it opens the next run
            kind_d    = K_STUFF;
            obit_d    = !st_q.last;
            st_d.last = !st_q.last;
            st_d.run  = RUN_W'(1);
            st_d.pend = 1'b0;
            st_d.cnt  = st_q.cnt + CNT_W'(1);
        end else if (accept) begin
            kind_d = K_DATA;
            obit_d = in_bit;
            if (stuffing) begin
                if (in_sof) begin
                    st_d.cnt    = '0;
                    st_d.region = 1'b1;
                end
                st_d.run  = ev_run;
                st_d.last = in_bit;
                st_d.pend = ev_hit;
            end else begin
                if (st_q.region) begin
                    done_d      = 1'b1;
                    st_d.region = 1'b0;
                end
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cst_out_reg u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind_d     (kind_d),
        .bit_d      (obit_d),
        .done_d     (done_d),
        .out_valid  (out_valid),
        .out_bit    (out_bit),
        .out_stuff  (out_stuff),
        .frame_done (frame_done)
    );

    assign stuff_count = st_q.cnt;
endmodule

// File: rtl/cst_checker.sv
module cst_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic in_bit,
    input logic out_valid,
    input logic out_bit,
    input logic out_stuff,
    input logic frame_done
);
    assert_accept_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !out_stuff && out_bit == $past(in_bit)));

    assert_stuff_opposite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_stuff |-> (out_bit != $past(out_bit)));

    assert_stall_gives_stuff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (out_valid && out_stuff));

    assert_stall_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_done_on_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (out_valid && !out_stuff));
endmodule

bind can_stuff_tx cst_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_bit     (in_bit),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .out_stuff  (out_stuff),
    .frame_done (frame_done)
);

// File: tb/tb_can_stuff_tx.sv
module tb_can_stuff_tx;
    localparam int RUN   = 5;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic             in_bit = 1'b0;
    logic             in_sof = 1'b0;
    logic             in_stuff_en = 1'b0;
    logic             out_valid;
    logic             out_bit;
    logic             out_stuff;
    logic             frame_done;
    logic [CNT_W-1:0] stuff_count;

    always #2 clk = !clk;

    can_stuff_tx #(.RUN_LIMIT(RUN), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .in_sof(in_sof), .in_stuff_en(in_stuff_en),
        .out_valid(out_valid), .out_bit(out_bit), .out_stuff(out_stuff),
        .frame_done(frame_done), .stuff_count(stuff_count)
    );

    int checks = 0;
    int fails  = 0;
    int exp_cnt = 0;
    bit exp_bit[$];
    bit exp_stf[$];
    bit exp_dne[$];
    logic prev_ready = 1'b1;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // output monitor: one expected entry per output cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (exp_bit.size() == 0) begin
                    chk(0, "R2 unexpected output bit", 1, 0);
                end else begin
                    bit eb, es, ed;
                    eb = exp_bit.pop_front();
                    es = exp_stf.pop_front();
                    ed = exp_dne.pop_front();
                    chk(out_bit == eb, es ? "R3/R4 stuff bit level" : "R2 data bit level", out_bit, eb);
                    chk(out_stuff == es, "R3 stuff marker", out_stuff, es);
                    chk(frame_done == ed, "R8 done pulse position", frame_done, ed);
                    if (es) chk(prev_ready == 1'b0, "R5 stall before stuff bit", prev_ready, 0);
                    if (ed) chk(int'(stuff_count) == exp_cnt, "R8 stuff count", stuff_count, exp_cnt);
                end
            end else begin
                chk(frame_done == 1'b0, "R8 done without output", frame_done, 0);
            end
            prev_ready = in_ready;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog expired", cycles, 150000);
            finish_up();
        end
    end

    task automatic send(input bit b, input bit sof, input bit en);
        in_valid    = 1'b1;
        in_bit      = b;
        in_sof      = sof;
        in_stuff_en = en;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // bit i of pat is sent i-th; bit 0 is start of frame
    task automatic run_frame(input logic [63:0] pat, input int nreg, input int ntail, input int gap);
        int run;
        bit last;
        int cnt;
        run = 0; last = 1'b0; cnt = 0;
        for (int i = 0; i < nreg; i++) begin
            bit b;
            b = pat[i];
            exp_bit.push_back(b); exp_stf.push_back(0); exp_dne.push_back(0);
            if (i == 0 || b != last) begin run = 1; last = b; end
            else run++;
            if (run == RUN) begin
                exp_bit.push_back(!b); exp_stf.push_back(1); exp_dne.push_back(0);
                last = !b; run = 1; cnt++;
            end
        end
        for (int i = nreg; i < nreg + ntail; i++) begin
            exp_bit.push_back(pat[i]); exp_stf.push_back(0); exp_dne.push_back(i == nreg);
        end
        exp_cnt = cnt;
        for (int i = 0; i < nreg + ntail; i++) begin
            send(pat[i], i == 0, i < nreg);
            if (gap > 0) begin
                in_valid = 1'b0;
                for (int g = 0; g < gap; g++) @(negedge clk);
            end
        end
        in_valid = 1'b0;
        for (int g = 0; g < 4; g++) @(negedge clk);
        chk(exp_bit.size() == 0, "R2 missing output bits", exp_bit.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);
        chk(frame_done == 1'b0, "R1 no done after reset", frame_done, 0);
        chk(stuff_count == '0, "R1 count after reset", stuff_count, 0);

        // R3 R4 R6 R9 sweep every 10-bit region body after the SOF bit
        for (int p = 0; p < 1024; p++) begin
            logic [63:0] pat;
            pat = '0;
            pat[10:1]  = p[9:0];
            pat[13:11] = p[2:0];
            run_frame(pat, 11, 3, (p % 7 == 3) ? 2 : 0);
        end

        // R4 long dominant run: stuff chain through the region
        run_frame(64'h0, 40, 2, 0);
        // R7 long equal tail outside the region is never stuffed
        run_frame({40'hFF_FFFF_FFFF, 24'h0007FE}, 11, 40, 1);
        // R6 second frame right away restarts run and count
        run_frame(64'h0000_0000_0F0F_F0F0, 32, 4, 0);
        run_frame(64'h0000_0000_0000_003E, 6, 1, 0);

        finish_up();
    end
endmodule